// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block models a parallel NOR flash device sitting on a simple synchronous memory bus. A host reads and writes it with a byte address, a write strobe and a read strobe. Plain reads return words from a small internal array. Writes are not stored directly. They are decoded as unlock-and-command sequences that select one of four operations: array read, single-word program, identification read and single-sector erase.

The address space begins with a group of small boot sectors, followed by larger uniform main sectors. An erase clears one whole sector to all ones. The size of that sector depends on whether the target address lies in the boot region. The erase walks the array one word per clock while a busy flag is high. Progress and completion are reported in bit 7 of a status byte. While a program, an erase setup or an erase is the current command, reads return that status byte instead of array data.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset every array word reads 0xFFFF, the device is in read mode, the status byte is 0, `erase_busy` is low and `rd_data` is 0.
- R2: In read mode, a read strobe returns the array word at byte address / 2, taken modulo the array depth, on `rd_data` one clock after the strobe.
- R3: A command sequence opens only with 0xAA written at byte address 0xAAAA, followed by 0x55 at 0x5554. Any other write in read mode, or a wrong second cycle, returns the device to read mode and leaves the array unchanged. Command values are compared on `wdata[7:0]` only.
- R4: A third write at 0xAAAA selects the command: 0x90 identification, 0xA0 program, 0x80 erase setup, 0xF0 read mode. Any other value aborts to read mode without arming anything.
- R5: Once program is armed, the next write stores its full data word at the addressed location. It also sets the status byte to bit 7 of that data, placed in bit 7, with all other status bits 0. Reads then return the status byte, zero-extended.
- R6: While program is the recorded command, writing 0xF0 at any address restores array reads.
- R7: In identification mode a read at word offset 0 returns ID_MFR (default 0x001F). Offset 1 returns ID_DEV (default 0x01D6), offset 2 returns 0, and any other offset returns all ones. The word offset is the low address byte divided by the bus width in bytes.
- R8: After erase setup, a second 0xAA/0x55 unlock pair followed by 0x30 at any address other than 0xAAAA erases the sector that holds that address to 0xFFFF. Below word 16 the sector is a 4-word boot sector; from word 16 up it is a 16-word main sector. In both cases the start is aligned down to the sector size. No other word changes.
- R9: The erase takes one clock per word with `erase_busy` high. During the walk, reads return the status byte with bit 7 clear and writes are ignored. When the walk ends, status bit 7 is set.
- R10: After an erase completes, writing 0xF0 returns the device to read mode.
- R11: While erase setup is the current command, reads return the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W (16) | Byte address for both reads and writes |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wdata | input | DATA_W (16) | Write data; the low byte carries command codes |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W (16) | Registered read result, valid the clock after `rd_en` |
| erase_busy | output | 1 | High while the sector erase walk runs |

## Verification
A wrong sequencer state appears at the ports on the very next read. Array data, status or an ID word comes back where another was due, so each sequence in the bench is followed directly by a read of the location or register that the fault would touch. An erase with the wrong size or alignment leaves a neighbour word cleared or a target word intact. This becomes visible only after the walk, so both sector edges are read back once `erase_busy` falls. A write wrongly accepted during the walk changes the mode, and the status read that follows completion exposes it.

// File: rtl/norseq_pkg.sv
// Package: shared command codes, magic unlock addresses and the sequencer
// mode encoding for the NOR flash command sequencer.
package norseq_pkg;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_SETUP    = 8'h80;
    localparam logic [7:0] CMD_SECTOR   = 8'h30;
    localparam logic [7:0] CMD_EXIT     = 8'hF0;

    localparam logic [15:0] UNLOCK_ADDR_1 = 16'hAAAA;
    localparam logic [15:0] UNLOCK_ADDR_2 = 16'h5554;

    // Combined write-cycle / current-command state
    typedef enum logic [2:0] {
        M_READ      = 3'd0,  // idle, array reads
        M_UNLK1     = 3'd1,  // first unlock cycle seen
        M_UNLK2     = 3'd2,  // second unlock cycle seen
        M_IDENT     = 3'd3,  // identification reads
        M_PROG_ARM  = 3'd4,  // next write programs
        M_PROG_IDLE = 3'd5,  // program done, status reads
        M_ESETUP    = 3'd6,  // erase setup, status reads
        M_SERASE    = 3'd7   // sector erase issued, status reads
    } mode_e;

endpackage

// File: rtl/norseq_array.sv
// Module: word-wide storage array built from per-word registers.
// Assumes at most one write per clock; every word resets to all ones,
// the erased state. Read port is combinational.
module norseq_array #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wd,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rd
);

    logic [DATA_W-1:0] rows [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [DATA_W-1:0] word_q;

        // Hold one word; load it when its index is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '1;
            else if (we && widx == IDX_W'(w))
                word_q <= wd;
        end

        assign rows[w] = word_q;
    end

    // Select the addressed word
    always_comb rd = rows[ridx];

endmodule

// File: rtl/norseq_eraser.sv
// Module: sector erase walker. On start it picks a boot or main sector size
// from the word index, aligns down, then steps one word per clock while busy.
// Assumes sector sizes are powers of two and start is only raised while idle.
module norseq_eraser #(
    parameter int DEPTH      = 64,
    parameter int BOOT_WORDS = 4,
    parameter int BOOT_COUNT = 4,
    parameter int MAIN_WORDS = 16,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int BOOT_AREA = BOOT_WORDS * BOOT_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] idx,
    output logic             busy,
    output logic [IDX_W-1:0] ptr,
    output logic             done
);

    logic             in_boot;
    logic [IDX_W-1:0] base_c;
    logic [IDX_W-1:0] last_c;
    logic [IDX_W-1:0] last_q;

    // Choose sector size and aligned bounds for the requested index
    always_comb begin
        in_boot = {1'b0, idx} < (IDX_W + 1)'(BOOT_AREA);
        if (in_boot) begin
            base_c = idx & ~IDX_W'(BOOT_WORDS - 1);
            last_c = base_c + IDX_W'(BOOT_WORDS - 1);
        end else begin
            base_c = idx & ~IDX_W'(MAIN_WORDS - 1);
            last_c = base_c + IDX_W'(MAIN_WORDS - 1);
        end
    end

    // Walk pointer from base to last, one word per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            ptr    <= '0;
            last_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                ptr    <= base_c;
                last_q <= last_c;
            end
        end else if (ptr == last_q) begin
            busy <= 1'b0;
        end else begin
            ptr <= ptr + 1'b1;
        end
    end

    // Final word of the walk is being cleared this cycle
    always_comb done = busy && (ptr == last_q);

endmodule

// File: rtl/norseq_decoder.sv
// Module: unlock/command sequence decoder and status byte owner.
// Assumes writes are already gated off while an erase walk is busy.
// Command codes are compared on the low data byte only.
module norseq_decoder
    import norseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        cmd_b,
    input  logic              erase_done,
    output mode_e             mode,
    output logic              prog_we,
    output logic              erase_start,
    output logic [7:0]        status
);

    mode_e mode_d;
    logic  armed_q, armed_d;
    logic  hit_u1, hit_u2;

    // Recognise the two magic unlock addresses
    always_comb begin
        hit_u1 = addr == ADDR_W'(UNLOCK_ADDR_1);
        hit_u2 = addr == ADDR_W'(UNLOCK_ADDR_2);
    end

    // Next-state decode for every accepted write
    always_comb begin
        mode_d      = mode;
        armed_d     = armed_q;
        prog_we     = 1'b0;
        erase_start = 1'b0;
        if (wr_acc) begin
            unique case (mode)
                M_READ, M_PROG_IDLE, M_IDENT, M_ESETUP: begin
                    if (hit_u1 && cmd_b == CMD_UNLOCK_A) begin
                        mode_d  = M_UNLK1;
                        armed_d = (mode == M_ESETUP);
                    end else begin
                        mode_d  = M_READ;
                        armed_d = 1'b0;
                    end
                end
                M_UNLK1: begin
                    if (hit_u2 && cmd_b == CMD_UNLOCK_B) begin
                        mode_d = M_UNLK2;
                    end else begin
                        mode_d  = M_READ;
                        armed_d = 1'b0;
                    end
                end
                M_UNLK2: begin
                    armed_d = 1'b0;
                    if (hit_u1) begin
                        case (cmd_b)
                            CMD_IDENT:   mode_d = M_IDENT;
                            CMD_SETUP:   mode_d = M_ESETUP;
                            CMD_PROGRAM: mode_d = M_PROG_ARM;
                            default:     mode_d = M_READ;
                        endcase
                    end else if (armed_q && cmd_b == CMD_SECTOR) begin
                        mode_d      = M_SERASE;
                        erase_start = 1'b1;
                    end else begin
                        mode_d = M_READ;
                    end
                end
                M_PROG_ARM: begin
                    prog_we = 1'b1;
                    mode_d  = M_PROG_IDLE;
                end
                M_SERASE: begin
                    if (cmd_b == CMD_EXIT)
                        mode_d = M_READ;
                end
                default: mode_d = M_READ;
            endcase
        end
    end

    // Register mode and the erase-setup flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= M_READ;
            armed_q <= 1'b0;
        end else begin
            mode    <= mode_d;
            armed_q <= armed_d;
        end
    end

    // Status byte: program mirrors data bit 7, erase clears then sets bit 7
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= 8'h00;
        else if (prog_we)
            status <= {cmd_b[7], 7'b0};
        else if (erase_start)
            status[7] <= 1'b0;
        else if (erase_done)
            status[7] <= 1'b1;
    end

endmodule

// File: rtl/nor_cmd_seq.sv
// Module: top of the NOR flash command sequencer. Ties the decoder, the
// erase walker and the array together and registers the read result.
// Assumes DATA_W is a multiple of 8 and ADDR_W >= 16.
module nor_cmd_seq
    import norseq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int BOOT_WORDS = 4,
    parameter int BOOT_COUNT = 4,
    parameter int MAIN_WORDS = 16,
    parameter int MAIN_COUNT = 3,
    parameter logic [DATA_W-1:0] ID_MFR = DATA_W'(16'h001F),
    parameter logic [DATA_W-1:0] ID_DEV = DATA_W'(16'h01D6)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              erase_busy
);

    localparam int DEPTH = BOOT_WORDS * BOOT_COUNT + MAIN_WORDS * MAIN_COUNT;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int BYTES = DATA_W / 8;
    localparam int BSH   = $clog2(BYTES);
    localparam int OFF_W = 8 - BSH;

    mode_e             mode;
    logic              prog_we;
    logic              erase_start;
    logic              erase_done;
    logic [7:0]        status;
    logic [IDX_W-1:0]  word_idx;
    logic [IDX_W-1:0]  walk_ptr;
    logic              arr_we;
    logic [IDX_W-1:0]  arr_widx;
    logic [DATA_W-1:0] arr_wd;
    logic [DATA_W-1:0] arr_rd;
    logic [OFF_W-1:0]  id_off;
    logic              status_sel;
    logic              wr_acc;

    // Address split and write gating during the erase walk
    always_comb begin
        word_idx = addr[BSH +: IDX_W];
        id_off   = addr[7:BSH];
        wr_acc   = wr_en && !erase_busy;
    end

    norseq_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_acc     (wr_acc),
        .addr       (addr),
        .cmd_b      (wdata[7:0]),
        .erase_done (erase_done),
        .mode       (mode),
        .prog_we    (prog_we),
        .erase_start(erase_start),
        .status     (status)
    );

    norseq_eraser #(
        .DEPTH     (DEPTH),
        .BOOT_WORDS(BOOT_WORDS),
        .BOOT_COUNT(BOOT_COUNT),
        .MAIN_WORDS(MAIN_WORDS)
    ) u_ers (
        .clk  (clk),
        .rst_n(rst_n),
        .start(erase_start),
        .idx  (word_idx),
        .busy (erase_busy),
        .ptr  (walk_ptr),
        .done (erase_done)
    );

    // Array write port: erase walk has priority over a program write
    always_comb begin
        arr_we   = prog_we || erase_busy;
        arr_widx = erase_busy ? walk_ptr : word_idx;
        arr_wd   = erase_busy ? '1 : wdata;
    end

    norseq_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_arr (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (arr_we),
        .widx (arr_widx),
        .wd   (arr_wd),
        .ridx (word_idx),
        .rd   (arr_rd)
    );

    // Modes in which reads show the status byte
    always_comb begin
        status_sel = erase_busy || mode == M_PROG_ARM || mode == M_PROG_IDLE
                  || mode == M_ESETUP || mode == M_SERASE;
    end

    // Registered read result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (status_sel)
                rd_data <= DATA_W'(status);
            else if (mode == M_IDENT) begin
                if (id_off == OFF_W'(0))      rd_data <= ID_MFR;
                else if (id_off == OFF_W'(1)) rd_data <= ID_DEV;
                else if (id_off == OFF_W'(2)) rd_data <= '0;
                else                          rd_data <= '1;
            end else
                rd_data <= arr_rd;
        end
    end

endmodule

// File: rtl/norseq_checker.sv
// Module: protocol checker for nor_cmd_seq, attached by bind.
// Assumes it sees the top's internal strobes between its submodules.
module norseq_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              busy,
    input logic              prog_we,
    input logic              erase_start,
    input logic              erase_done,
    input logic [7:0]        status
);

    // R9: no program write lands while the walk owns the array
    assert_no_prog_in_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !prog_we);

    // R9: a new erase never starts during a walk
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !erase_start);

    // R8: an accepted erase command starts the walk on the next clock
    assert_walk_follows_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> busy);

    // R9: reads during the walk show status with bit 7 clear
    assert_busy_read_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> rd_data[DATA_W-1:7] == '0);

    // R9: the end of the walk sets the ready bit
    assert_done_sets_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |=> status[7]);

    // R5: after a program write only bit 7 of status may be set
    assert_prog_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |=> status[6:0] == 7'b0);

endmodule

bind nor_cmd_seq norseq_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .busy       (erase_busy),
    .prog_we    (prog_we),
    .erase_start(erase_start),
    .erase_done (erase_done),
    .status     (status)
);

// File: tb/sim_nor_cmd_seq.sv
`timescale 1ns/100ps
// Bench: vector table walk followed by directed erase and reset checks.
module sim_nor_cmd_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        erase_busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    nor_cmd_seq u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .erase_busy(erase_busy)
    );

    // {is_read, addr, data_or_expected, requirement}
    localparam int NV = 38;
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 16'h0000, 16'hFFFF, 8'd1},  // R1 erased after reset
        {1'b0, 16'hAAAA, 16'h00AA, 8'd3},  // R3
        {1'b0, 16'h5554, 16'h0055, 8'd3},
        {1'b0, 16'hAAAA, 16'h00A0, 8'd4},  // R4 program
        {1'b0, 16'h0010, 16'h1234, 8'd5},  // R5
        {1'b1, 16'h0010, 16'h0000, 8'd5},  // R5 status bit7 = 0
        {1'b0, 16'h0000, 16'h00F0, 8'd6},  // R6
        {1'b1, 16'h0010, 16'h1234, 8'd6},
        {1'b0, 16'hAAAA, 16'h00AA, 8'd3},
        {1'b0, 16'h5554, 16'h0055, 8'd3},
        {1'b0, 16'hAAAA, 16'h00A0, 8'd4},
        {1'b0, 16'h0040, 16'h0080, 8'd5},
        {1'b1, 16'h0040, 16'h0080, 8'd5},  // R5 status bit7 = 1
        {1'b0, 16'h0000, 16'h00F0, 8'd6},
        {1'b1, 16'h0040, 16'h0080, 8'd2},  // R2
        {1'b0, 16'hAAAA, 16'h00AA, 8'd3},
        {1'b0, 16'h5554, 16'h0055, 8'd3},
        {1'b0, 16'hAAAA, 16'h0090, 8'd4},  // R4 ident
        {1'b1, 16'h0000, 16'h001F, 8'd7},  // R7
        {1'b1, 16'h0002, 16'h01D6, 8'd7},
        {1'b1, 16'h0004, 16'h0000, 8'd7},
        {1'b1, 16'h0006, 16'hFFFF, 8'd7},
        {1'b0, 16'hAAAA, 16'h00AA, 8'd3},
        {1'b0, 16'h5554, 16'h0055, 8'd3},
        {1'b0, 16'hAAAA, 16'h00F0, 8'd4},  // R4 exit
        {1'b1, 16'h0010, 16'h1234, 8'd4},
        {1'b0, 16'hAAAA, 16'h00AA, 8'd3},
        {1'b0, 16'h5554, 16'h0066, 8'd3},  // R3 bad second cycle
        {1'b1, 16'h0010, 16'h1234, 8'd3},
        {1'b0, 16'h5554, 16'h0055, 8'd3},  // R3 stray write in read mode
        {1'b0, 16'hAAAA, 16'h00A0, 8'd3},
        {1'b0, 16'h0012, 16'h5555, 8'd3},
        {1'b1, 16'h0012, 16'hFFFF, 8'd3},
        {1'b0, 16'hAAAA, 16'h00AA, 8'd4},
        {1'b0, 16'h5554, 16'h0055, 8'd4},
        {1'b0, 16'hAAAA, 16'h0077, 8'd4},  // R4 unknown command
        {1'b0, 16'h0014, 16'h4444, 8'd4},
        {1'b1, 16'h0014, 16'hFFFF, 8'd4}
    };

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [15:0] exp, input int req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        #1 check(req, rd_data, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic unlock();
        wr(16'hAAAA, 16'h00AA);
        wr(16'h5554, 16'h0055);
    endtask

    task automatic program_word(input logic [15:0] a, input logic [15:0] d);
        unlock();
        wr(16'hAAAA, 16'h00A0);
        wr(a, d);
        wr(16'h0000, 16'h00F0);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check(1, rd_data, 16'h0000);              // R1 reset read data
        check(1, {15'b0, erase_busy}, 16'h0000);  // R1 idle walker

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][40])
                rd_chk(VEC[i][39:24], VEC[i][23:8], int'(VEC[i][7:0]));
            else
                wr(VEC[i][39:24], VEC[i][23:8]);
        end

        // R8 boot sector erase: words 8..11
        program_word(16'h0012, 16'h1111);
        program_word(16'h0018, 16'h00C3);
        unlock();
        wr(16'hAAAA, 16'h0080);
        rd_chk(16'h0000, 16'h0080, 11);           // R11 setup shows status
        unlock();
        wr(16'h0012, 16'h0030);
        #1 check(9, {15'b0, erase_busy}, 16'h0001); // R9 busy during walk
        rd_chk(16'h0000, 16'h0000, 9);            // R9 status, bit7 clear
        repeat (10) @(posedge clk);
        check(9, {15'b0, erase_busy}, 16'h0000);
        rd_chk(16'h0000, 16'h0080, 9);            // R9 ready
        wr(16'h0000, 16'h00F0);                   // R10
        rd_chk(16'h0010, 16'hFFFF, 8);
        rd_chk(16'h0012, 16'hFFFF, 8);
        rd_chk(16'h0018, 16'h00C3, 8);            // R8 neighbour kept
        rd_chk(16'h0040, 16'h0080, 10);           // R10 array reads back

        // R8 main sector erase: words 32..47
        program_word(16'h005E, 16'hBEEF);
        program_word(16'h0060, 16'h5A5A);
        unlock();
        wr(16'hAAAA, 16'h0080);
        unlock();
        wr(16'h0046, 16'h0030);
        wr(16'h0000, 16'h00F0);                   // R9 ignored while busy
        rd_chk(16'h0040, 16'h0000, 9);
        repeat (20) @(posedge clk);
        rd_chk(16'h0040, 16'h0080, 9);            // R9 write was ignored
        wr(16'h0000, 16'h00F0);                   // R10
        rd_chk(16'h0040, 16'hFFFF, 8);
        rd_chk(16'h005E, 16'hFFFF, 8);
        rd_chk(16'h0060, 16'h5A5A, 8);
        rd_chk(16'h0018, 16'h00C3, 8);

        // R1 reset mid-sequence restores erased array and read mode
        unlock();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        rd_chk(16'h0060, 16'hFFFF, 1);
        rd_chk(16'h0018, 16'hFFFF, 1);

        finish_run();
    end

endmodule